// File: doc/BRIEF.md
# Masked Broadcast Write Fabric for Per-Core Lookup Memories

This block links sixteen cores, each owning a lookup memory of 512 words of 32 bits. On any clock, a core may post a write request: a write strobe, a 16-bit destination mask, a 9-bit word address and a 32-bit data word. Every set mask bit names one destination memory. One request can therefore reach a single peer, a group of peers or every other core at once. The fabric writes only. A core receives a reply only when the peer posts its own request into the first core's memory, so a two-way channel uses both memories.

Every destination has a second RAM port. That port gates each source's strobe, address and data with that source's mask bit for the destination, then ORs the gated terms of all sources together. There is no arbitration, no stall and no collision flag. Two sources that hit the same memory in the same clock store the bitwise OR of their addresses and of their data. The first clock registers the merged request for each destination. The second clock commits it to the RAM. The first port of each memory belongs to its owning core, which reads and writes it locally with no link to the fabric.

Top module: `lut_bcast_fabric`

## Requirements
- R1: When source s posts a request with its strobe high and only mask bit d set (bit d of the source's 16-bit mask field selects core d), memory d stores the request's data at the request's address. The same word of every other memory is left unchanged.
- R2: A request with several mask bits set writes the same address and data into every selected memory in the same clock, up to all fifteen other memories.
- R3: A source's mask bit for its own core index has no effect. The fabric never writes the requester's own memory.
- R4: A request with its strobe low, or with an all-zero mask, changes no memory.
- R5: When two or more sources target one memory in the same clock, that memory is written once, at the bitwise OR of their addresses, with the bitwise OR of their data. Writes to other destinations in that clock are not affected.
- R6: A request sampled at clock edge k is committed at edge k+1. A local read sampled at edge k+1 returns the old word. A local read sampled at edge k+2 returns the new word.
- R7: The local port reads and writes its own memory. A read sampled at one edge presents the word on its output after that edge and holds it until the next read.
- R8: While reset is active the merge stage is cleared and every local read output is zero. After reset, no memory is written until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqWe | input | 16 | Write strobe of each source core |
| reqMask | input | 256 | Destination masks; bits [s*16 +: 16] belong to source s, bit d selects core d |
| reqAddr | input | 144 | Word address of each source, [s*9 +: 9] |
| reqData | input | 512 | Data word of each source, [s*32 +: 32] |
| locEn | input | 16 | Local port enable for each core |
| locWe | input | 16 | Local port write select, 1 = write, 0 = read |
| locAddr | input | 144 | Local port word address, [c*9 +: 9] |
| locWdata | input | 512 | Local port write data, [c*32 +: 32] |
| locRdata | output | 512 | Local port read data, [c*32 +: 32] |

## Verification
The hardest case to produce is a collision: two sources must post into one memory on exactly the same clock edge, and the result appears only at a third address that neither of them named. The stimulus therefore drives two sources' request fields from a single task in one cycle. It preloads the two named words and their OR address with zero through the local port, so any stray write shows up. It also gives one of the colliding sources a second, private destination, to show that the merge does not reach other memories. The two-clock latency is pinned by a local read placed right after the request, which must still return the preloaded word.

// File: rtl/lut_fabric_pkg.sv
`timescale 1ns/1ps
package lut_fabric_pkg;
  parameter int CORE_COUNT  = 16;
  parameter int WORD_ADDR_W = 9;
  parameter int WORD_DATA_W = 32;
  localparam int WORD_DEPTH = 1 << WORD_ADDR_W;

  typedef logic [CORE_COUNT-1:0] coreVec_t;

  // Strobes from control to datapath: gate[d][s] = source s writes core d
  typedef struct packed {
    coreVec_t [CORE_COUNT-1:0] gate;
    coreVec_t                  hit;
  } fabStrobe_t;
endpackage

// File: rtl/fabric_ctrl.sv
`timescale 1ns/1ps
module fabric_ctrl
  import lut_fabric_pkg::*;
(
  input  coreVec_t                        reqWe,
  input  logic [CORE_COUNT*CORE_COUNT-1:0] reqMask,
  output fabStrobe_t                      strobe
);
  always_comb begin
    strobe = '0;
    for (int d = 0; d < CORE_COUNT; d++) begin
      for (int s = 0; s < CORE_COUNT; s++) begin
        // own-index bit is dropped so a core never writes itself
        strobe.gate[d][s] = reqWe[s] & reqMask[s*CORE_COUNT+d] & (s != d);
      end
      strobe.hit[d] = |strobe.gate[d];
    end
  end
endmodule

// File: rtl/fabric_datapath.sv
`timescale 1ns/1ps
module fabric_datapath
  import lut_fabric_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   rstN,
  input  fabStrobe_t                             strobe,
  input  coreVec_t                               reqWe,
  input  logic [CORE_COUNT*CORE_COUNT-1:0]        reqMask,
  input  logic [CORE_COUNT-1:0][WORD_ADDR_W-1:0] reqAddr,
  input  logic [CORE_COUNT-1:0][WORD_DATA_W-1:0] reqData,
  output coreVec_t                               stgWe,
  output logic [CORE_COUNT-1:0][WORD_ADDR_W-1:0] stgAddr,
  output logic [CORE_COUNT-1:0][WORD_DATA_W-1:0] stgData
);
  logic [CORE_COUNT-1:0][WORD_ADDR_W-1:0] mrgAddr;
  logic [CORE_COUNT-1:0][WORD_DATA_W-1:0] mrgData;

  // AND-OR merge per destination
  always_comb begin
    mrgAddr = '0;
    mrgData = '0;
    for (int d = 0; d < CORE_COUNT; d++) begin
      for (int s = 0; s < CORE_COUNT; s++) begin
        mrgAddr[d] = mrgAddr[d] | (reqAddr[s] & {WORD_ADDR_W{strobe.gate[d][s]}});
        mrgData[d] = mrgData[d] | (reqData[s] & {WORD_DATA_W{strobe.gate[d][s]}});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stgWe <= '0;
    else       stgWe <= strobe.hit;
  end

  always_ff @(posedge clk) begin
    stgAddr <= mrgAddr;
    stgData <= mrgData;
  end

  for (genvar d = 0; d < CORE_COUNT; d++) begin : g_chk_dst
    localparam coreVec_t SELF_ONLY = coreVec_t'(1) << d;

    AST_STAGE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
      stgWe[d] |-> $past(reqWe != '0)); // R4

    AST_SELF_SKIP: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(reqWe == SELF_ONLY)) |-> !stgWe[d]); // R3

    for (genvar s = 0; s < CORE_COUNT; s++) begin : g_chk_src
      if (s != d) begin : g_pair
        AST_ADDR_OR_COVER: assert property (@(posedge clk) disable iff (!rstN)
          $past(reqWe[s] && reqMask[s*CORE_COUNT+d])
          |-> (stgWe[d] && ((stgAddr[d] | $past(reqAddr[s])) == stgAddr[d]))); // R5

        AST_DATA_OR_COVER: assert property (@(posedge clk) disable iff (!rstN)
          $past(reqWe[s] && reqMask[s*CORE_COUNT+d])
          |-> ((stgData[d] | $past(reqData[s])) == stgData[d])); // R5
      end
    end
  end
endmodule

// File: rtl/lut_bank.sv
`timescale 1ns/1ps
module lut_bank
  import lut_fabric_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   locEn,
  input  logic                   locWe,
  input  logic [WORD_ADDR_W-1:0] locAddr,
  input  logic [WORD_DATA_W-1:0] locWdata,
  output logic [WORD_DATA_W-1:0] locRdata,
  input  logic                   fabWe,
  input  logic [WORD_ADDR_W-1:0] fabAddr,
  input  logic [WORD_DATA_W-1:0] fabData
);
  logic [WORD_DATA_W-1:0] mem [WORD_DEPTH];

  always_ff @(posedge clk) begin
    if (locEn && locWe) mem[locAddr] <= locWdata;
    if (fabWe)          mem[fabAddr] <= fabData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                locRdata <= '0;
    else if (locEn && !locWe) locRdata <= mem[locAddr];
  end

  AST_FAB_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (fabWe && !(locEn && locWe)) |=> mem[$past(fabAddr)] == $past(fabData)); // R6

  AST_LOCAL_READ: assert property (@(posedge clk) disable iff (!rstN)
    (locEn && !locWe) |=> locRdata == $past(mem[locAddr])); // R7

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |=> locRdata == '0); // R8
endmodule

// File: rtl/lut_bcast_fabric.sv
`timescale 1ns/1ps
module lut_bcast_fabric
  import lut_fabric_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [CORE_COUNT-1:0]              reqWe,
  input  logic [CORE_COUNT*CORE_COUNT-1:0]   reqMask,
  input  logic [CORE_COUNT*WORD_ADDR_W-1:0]  reqAddr,
  input  logic [CORE_COUNT*WORD_DATA_W-1:0]  reqData,
  input  logic [CORE_COUNT-1:0]              locEn,
  input  logic [CORE_COUNT-1:0]              locWe,
  input  logic [CORE_COUNT*WORD_ADDR_W-1:0]  locAddr,
  input  logic [CORE_COUNT*WORD_DATA_W-1:0]  locWdata,
  output logic [CORE_COUNT*WORD_DATA_W-1:0]  locRdata
);
  fabStrobe_t                             strobe;
  coreVec_t                               stgWe;
  logic [CORE_COUNT-1:0][WORD_ADDR_W-1:0] stgAddr;
  logic [CORE_COUNT-1:0][WORD_DATA_W-1:0] stgData;
  logic [CORE_COUNT-1:0][WORD_ADDR_W-1:0] reqAddrV;
  logic [CORE_COUNT-1:0][WORD_DATA_W-1:0] reqDataV;

  assign reqAddrV = reqAddr;
  assign reqDataV = reqData;

  fabric_ctrl i_ctrl (
    .reqWe   (reqWe),
    .reqMask (reqMask),
    .strobe  (strobe)
  );

  fabric_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqWe   (reqWe),
    .reqMask (reqMask),
    .reqAddr (reqAddrV),
    .reqData (reqDataV),
    .stgWe   (stgWe),
    .stgAddr (stgAddr),
    .stgData (stgData)
  );

  for (genvar c = 0; c < CORE_COUNT; c++) begin : g_bank
    lut_bank i_bank (
      .clk      (clk),
      .rstN     (rstN),
      .locEn    (locEn[c]),
      .locWe    (locWe[c]),
      .locAddr  (locAddr[c*WORD_ADDR_W +: WORD_ADDR_W]),
      .locWdata (locWdata[c*WORD_DATA_W +: WORD_DATA_W]),
      .locRdata (locRdata[c*WORD_DATA_W +: WORD_DATA_W]),
      .fabWe    (stgWe[c]),
      .fabAddr  (stgAddr[c]),
      .fabData  (stgData[c])
    );
  end
endmodule

// File: tb/test_lut_bcast_fabric.sv
`timescale 1ns/1ps
module test_lut_bcast_fabric;
  localparam int N  = 16;
  localparam int AW = 9;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rstN;
  logic [N-1:0]    reqWe;
  logic [N*N-1:0]  reqMask;
  logic [N*AW-1:0] reqAddr;
  logic [N*DW-1:0] reqData;
  logic [N-1:0]    locEn;
  logic [N-1:0]    locWe;
  logic [N*AW-1:0] locAddr;
  logic [N*DW-1:0] locWdata;
  logic [N*DW-1:0] locRdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int          core;
    logic [31:0] exp;
    int          due;
    string       tag;
  } sbItem_t;
  sbItem_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lut_bcast_fabric i_lut_bcast_fabric (
    .clk(clk), .rstN(rstN), .reqWe(reqWe), .reqMask(reqMask),
    .reqAddr(reqAddr), .reqData(reqData), .locEn(locEn), .locWe(locWe),
    .locAddr(locAddr), .locWdata(locWdata), .locRdata(locRdata)
  );

  // monitor: pops expected read results when they fall due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      sbItem_t it;
      it = sb.pop_front();
      checks++;
      if (locRdata[it.core*DW +: DW] !== it.exp) begin
        fails++;
        $display("FAIL %s core %0d: actual %h expected %h",
                 it.tag, it.core, locRdata[it.core*DW +: DW], it.exp);
      end
    end
  end

  task automatic clearReq();
    reqWe = '0; reqMask = '0; reqAddr = '0; reqData = '0;
  endtask

  task automatic setReq(input int src, input logic we, input logic [15:0] mask,
                        input logic [8:0] a, input logic [31:0] d);
    reqWe[src]            = we;
    reqMask[src*N +: N]   = mask;
    reqAddr[src*AW +: AW] = a;
    reqData[src*DW +: DW] = d;
  endtask

  // all tasks enter and leave at a falling edge
  task automatic fabReq(input int src, input logic we, input logic [15:0] mask,
                        input logic [8:0] a, input logic [31:0] d);
    setReq(src, we, mask, a, d);
    @(negedge clk);
    clearReq();
  endtask

  task automatic locWrite(input int core, input logic [8:0] a, input logic [31:0] d);
    locEn[core] = 1'b1; locWe[core] = 1'b1;
    locAddr[core*AW +: AW] = a; locWdata[core*DW +: DW] = d;
    @(negedge clk);
    locEn = '0; locWe = '0;
  endtask

  task automatic locRead(input int core, input logic [8:0] a,
                         input logic [31:0] exp, input string tag);
    sbItem_t it;
    locEn[core] = 1'b1; locWe[core] = 1'b0;
    locAddr[core*AW +: AW] = a;
    it.core = core; it.exp = exp; it.due = cyc + 1; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    locEn = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0;
    clearReq();
    locEn = '0; locWe = '0; locAddr = '0; locWdata = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (locRdata !== '0) begin
      fails++;
      $display("FAIL R8 reset read data: actual %h expected 0", locRdata);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R8: after reset nothing is written without a request
    locWrite(11, 9'h0AA, 32'hC0DE_0011);
    idle(3);
    locRead(11, 9'h0AA, 32'hC0DE_0011, "R8 no spurious write");

    // R7: local port write then read
    locWrite(3, 9'h005, 32'hDEAD_BEEF);
    locRead(3, 9'h005, 32'hDEAD_BEEF, "R7 local rw");
    locRead(3, 9'h005, 32'hDEAD_BEEF, "R7 local reread");

    // R1 + R6: single target, latency
    locWrite(7, 9'h020, 32'h1111_1111);
    locWrite(8, 9'h020, 32'h2222_2222);
    fabReq(2, 1'b1, 16'h0080, 9'h020, 32'hA5A5_0007);
    locRead(7, 9'h020, 32'h1111_1111, "R6 old word one clock after");
    locRead(7, 9'h020, 32'hA5A5_0007, "R1 R6 new word two clocks after");
    locRead(8, 9'h020, 32'h2222_2222, "R1 untargeted memory");

    // R2 + R3: broadcast from core 0 including its own bit
    locWrite(0, 9'h040, 32'h0BAD_0000);
    fabReq(0, 1'b1, 16'hFFFF, 9'h040, 32'hB0AD_CA57);
    idle(1);
    for (int c = 1; c < N; c++) locRead(c, 9'h040, 32'hB0AD_CA57, "R2 broadcast");
    locRead(0, 9'h040, 32'h0BAD_0000, "R3 broadcast skips own");

    // R3: self-only mask
    locWrite(6, 9'h066, 32'h6666_6666);
    fabReq(6, 1'b1, 16'h0040, 9'h066, 32'h0000_0BAD);
    idle(1);
    locRead(6, 9'h066, 32'h6666_6666, "R3 self-only mask");

    // R4: strobe low, then zero mask
    locWrite(5, 9'h050, 32'h5555_AAAA);
    fabReq(1, 1'b0, 16'h0020, 9'h050, 32'hFFFF_FFFF);
    idle(1);
    locRead(5, 9'h050, 32'h5555_AAAA, "R4 strobe low");
    fabReq(1, 1'b1, 16'h0000, 9'h050, 32'hFFFF_FFFF);
    idle(1);
    locRead(5, 9'h050, 32'h5555_AAAA, "R4 zero mask");

    // R5: collision of sources 1 and 4 on core 9; source 4 also hits core 10
    locWrite(9, 9'h011, 32'h0);
    locWrite(9, 9'h102, 32'h0);
    locWrite(9, 9'h113, 32'h0);
    locWrite(10, 9'h102, 32'h0);
    setReq(1, 1'b1, 16'h0200, 9'h011, 32'h0000_F0F0);
    setReq(4, 1'b1, 16'h0600, 9'h102, 32'h1234_0000);
    @(negedge clk);
    clearReq();
    idle(1);
    locRead(9, 9'h113, 32'h1234_F0F0, "R5 merged address gets merged data");
    locRead(9, 9'h011, 32'h0, "R5 first named word untouched");
    locRead(9, 9'h102, 32'h0, "R5 second named word untouched");
    locRead(10, 9'h102, 32'h1234_0000, "R5 other destination exact");

    idle(3);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule